// File: doc/BRIEF.md
# Signed-Digit Modular Multiplier (radix-4 digit pairs)

This block multiplies two radix-2 signed-digit operands and returns their product as a signed-digit value of the same length, reduced modulo 2^N−1, 2^N or 2^N+1. A parameter picks the modulus. Each digit of an operand lies in {−1, 0, +1}. Each digit is carried on two wires, one for the positive sign and one for the negative sign. The block is purely combinational.

The multiplier operand is read two digits at a time. Each pair selects one of the multiples 0, ±x, ±2x and ±3x of the multiplicand. Only the triple needs logic: a single modular signed-digit adder forms it from x and 2x. Doubling and negation are plain wiring. The selected multiple of pair i is scaled by 4^i through a wired modular rotation. The N/2 scaled partial products are then reduced by a balanced tree of carry-free modular signed-digit adders. The result may use the negative part of the range. Only its residue is defined, not its exact digit pattern.

Top module: `sd_modmul`

## Requirements
- R1: Digit i of a vector pair is +1 when only its `_pos` bit is set, −1 when only its `_neg` bit is set, and 0 when neither is set. Inputs never set both bits of a digit. The block never sets both bits of any output digit.
- R2: With MODE = MOD_MINUS1, the value of p is congruent to value(x)·value(y) modulo 2^N−1.
- R3: With MODE = MOD_POW2, the value of p is congruent to value(x)·value(y) modulo 2^N.
- R4: With MODE = MOD_PLUS1 (the default), the value of p is congruent to value(x)·value(y) modulo 2^N+1.
- R5: When either operand has all digits zero, every digit of p is zero in all modes.
- R6: A low multiplier digit pair (high digit, low digit) of (+1, −1) gives exactly the same output digits as the pair (0, +1), since both select +x.
- R7: The output depends only on the present inputs. A result is valid in the same cycle as its operands, with no clock and no stored state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| x_pos | input | N | Multiplicand, positive-digit flags |
| x_neg | input | N | Multiplicand, negative-digit flags |
| y_pos | input | N | Multiplier, positive-digit flags |
| y_neg | input | N | Multiplier, negative-digit flags |
| p_pos | output | N | Modular product, positive-digit flags |
| p_neg | output | N | Modular product, negative-digit flags |

## Verification
The product has no register on its path, so every result is due in the same cycle as the operands that produce it (R7). The bench changes the operands just after a rising edge of its pacing clock. It reads the outputs at the following falling edge, once the combinational tree has settled. Three instances, one per modulus, see the same operands. Each vector is therefore checked against all three congruences before the next vector is applied.

// File: rtl/sdm_pkg.sv
package sdm_pkg;

  // Which modulus the block reduces by.
  typedef enum logic [1:0] {
    MOD_MINUS1 = 2'd0,  // 2^N - 1
    MOD_POW2   = 2'd1,  // 2^N
    MOD_PLUS1  = 2'd2   // 2^N + 1
  } mod_e;

  // Carry and interim digit produced at one adder position.
  typedef struct packed {
    logic cpos;
    logic cneg;
    logic upos;
    logic uneg;
  } split_t;

  // Digit-pair weight 2*hi + lo, in the range -3..3.
  function automatic int pair_weight(input logic hp, input logic hn,
                                     input logic lp, input logic ln);
    return 2 * (int'(hp) - int'(hn)) + int'(lp) - int'(ln);
  endfunction

  // Splits the digit sum a+b into carry and interim digit.
  // lo_nonneg: the carry entering this position cannot be negative.
  function automatic split_t add_split(input logic ap, input logic an,
                                       input logic bp, input logic bn,
                                       input logic lo_nonneg);
    int s;
    split_t r;
    s = int'(ap) + int'(bp) - int'(an) - int'(bn);
    r = '0;
    case (s)
      2:  r.cpos = 1'b1;
      -2: r.cneg = 1'b1;
      1: begin
        if (lo_nonneg) begin r.cpos = 1'b1; r.uneg = 1'b1; end
        else           r.upos = 1'b1;
      end
      -1: begin
        if (lo_nonneg) r.uneg = 1'b1;
        else begin r.cneg = 1'b1; r.upos = 1'b1; end
      end
      default: r = '0;
    endcase
    return r;
  endfunction

  // Integer value of an SD vector (up to 32 digits): positive flags minus negative flags.
  function automatic longint sd_val(input logic [31:0] pos, input logic [31:0] neg);
    return longint'(pos) - longint'(neg);
  endfunction

endpackage

// File: rtl/sd_scale.sv
// Multiplies an SD vector by 2^SHIFT modulo the chosen modulus, by wiring alone.
module sd_scale
  import sdm_pkg::*;
#(
  parameter int   N     = 6,
  parameter int   SHIFT = 1,
  parameter mod_e MODE  = MOD_PLUS1
) (
  input  logic [N-1:0] i_pos,
  input  logic [N-1:0] i_neg,
  output logic [N-1:0] o_pos,
  output logic [N-1:0] o_neg
);

  for (genvar j = 0; j < N; j++) begin : g_dig
    if (j >= SHIFT) begin : g_move
      assign o_pos[j] = i_pos[j-SHIFT];
      assign o_neg[j] = i_neg[j-SHIFT];
    end else if (MODE == MOD_MINUS1) begin : g_rot
      assign o_pos[j] = i_pos[N-SHIFT+j];
      assign o_neg[j] = i_neg[N-SHIFT+j];
    end else if (MODE == MOD_PLUS1) begin : g_rotneg
      assign o_pos[j] = i_neg[N-SHIFT+j];
      assign o_neg[j] = i_pos[N-SHIFT+j];
    end else begin : g_zero
      assign o_pos[j] = 1'b0;
      assign o_neg[j] = 1'b0;
    end
  end

endmodule

// File: rtl/sd_modadd.sv
// Carry-free modular SD adder with end-around carry chosen by MODE.
module sd_modadd
  import sdm_pkg::*;
#(
  parameter int   N    = 6,
  parameter mod_e MODE = MOD_PLUS1
) (
  input  logic [N-1:0] a_pos,
  input  logic [N-1:0] a_neg,
  input  logic [N-1:0] b_pos,
  input  logic [N-1:0] b_neg,
  output logic [N-1:0] s_pos,
  output logic [N-1:0] s_neg
);

  logic         wrap_ok;
  logic [N-1:0] low_ok;
  logic [N-1:0] co_pos, co_neg, u_pos, u_neg;
  logic [N-1:0] ci_pos, ci_neg;
  logic         wrap_cpos, wrap_cneg;

  // Sign of the carry that will enter position 0, known from the top pair.
  assign wrap_ok = (MODE == MOD_MINUS1) ? ~(a_neg[N-1] | b_neg[N-1]) :
                   (MODE == MOD_PLUS1)  ? ~(a_pos[N-1] | b_pos[N-1]) : 1'b1;
  assign low_ok  = {~(a_neg[N-2:0] | b_neg[N-2:0]), wrap_ok};

  always_comb begin
    for (int i = 0; i < N; i++) begin
      split_t r;
      r = add_split(a_pos[i], a_neg[i], b_pos[i], b_neg[i], low_ok[i]);
      co_pos[i] = r.cpos;
      co_neg[i] = r.cneg;
      u_pos[i]  = r.upos;
      u_neg[i]  = r.uneg;
    end
  end

  // End-around carry: kept, dropped, or negated.
  assign wrap_cpos = (MODE == MOD_MINUS1) ? co_pos[N-1] :
                     (MODE == MOD_PLUS1)  ? co_neg[N-1] : 1'b0;
  assign wrap_cneg = (MODE == MOD_MINUS1) ? co_neg[N-1] :
                     (MODE == MOD_PLUS1)  ? co_pos[N-1] : 1'b0;
  assign ci_pos = {co_pos[N-2:0], wrap_cpos};
  assign ci_neg = {co_neg[N-2:0], wrap_cneg};

  // Interim digit plus incoming carry never leaves {-1,0,+1}.
  assign s_pos = (u_pos | ci_pos) & ~(u_neg | ci_neg);
  assign s_neg = (u_neg | ci_neg) & ~(u_pos | ci_pos);

endmodule

// File: rtl/sd_ppsel.sv
// Picks 0, +-x, +-2x or +-3x for one multiplier digit pair.
module sd_ppsel
  import sdm_pkg::*;
#(
  parameter int N = 6
) (
  input  logic [N-1:0] x1_pos,
  input  logic [N-1:0] x1_neg,
  input  logic [N-1:0] x2_pos,
  input  logic [N-1:0] x2_neg,
  input  logic [N-1:0] x3_pos,
  input  logic [N-1:0] x3_neg,
  input  logic         hi_pos,
  input  logic         hi_neg,
  input  logic         lo_pos,
  input  logic         lo_neg,
  output logic [N-1:0] r_pos,
  output logic [N-1:0] r_neg
);

  int           w;
  int           mag;
  logic [N-1:0] m_pos, m_neg;

  always_comb begin
    w   = pair_weight(hi_pos, hi_neg, lo_pos, lo_neg);
    mag = (w < 0) ? -w : w;
    case (mag)
      1:       begin m_pos = x1_pos; m_neg = x1_neg; end
      2:       begin m_pos = x2_pos; m_neg = x2_neg; end
      3:       begin m_pos = x3_pos; m_neg = x3_neg; end
      default: begin m_pos = '0;     m_neg = '0;     end
    endcase
    if (w < 0) begin
      r_pos = m_neg;
      r_neg = m_pos;
    end else begin
      r_pos = m_pos;
      r_neg = m_neg;
    end
  end

endmodule

// File: rtl/sd_modmul.sv
// Combinational SD modular multiplier: digit-pair selection and adder tree.
module sd_modmul
  import sdm_pkg::*;
#(
  parameter int   N    = 6,
  parameter mod_e MODE = MOD_PLUS1
) (
  input  logic [N-1:0] x_pos,
  input  logic [N-1:0] x_neg,
  input  logic [N-1:0] y_pos,
  input  logic [N-1:0] y_neg,
  output logic [N-1:0] p_pos,
  output logic [N-1:0] p_neg
);

  localparam int K      = N / 2;
  localparam int LEVELS = (K > 1) ? $clog2(K) : 0;
  localparam int LEAVES = 1 << LEVELS;
  localparam int NODES  = 2 * LEAVES - 1;

  // Named internal results, also observed by the checker.
  logic [N-1:0]   x2_pos, x2_neg, x3_pos, x3_neg;
  logic [N-1:0]   rp_pos [K];
  logic [N-1:0]   rp_neg [K];
  logic [N-1:0]   pp_pos [K];
  logic [N-1:0]   pp_neg [K];
  logic [K*N-1:0] pp_all_pos, pp_all_neg;
  logic [N-1:0]   nd_pos [NODES];
  logic [N-1:0]   nd_neg [NODES];

  sd_scale #(.N(N), .SHIFT(1), .MODE(MODE)) u_dbl (
    .i_pos(x_pos), .i_neg(x_neg), .o_pos(x2_pos), .o_neg(x2_neg)
  );

  sd_modadd #(.N(N), .MODE(MODE)) u_tri (
    .a_pos(x_pos), .a_neg(x_neg), .b_pos(x2_pos), .b_neg(x2_neg),
    .s_pos(x3_pos), .s_neg(x3_neg)
  );

  for (genvar i = 0; i < K; i++) begin : g_pp
    sd_ppsel #(.N(N)) u_sel (
      .x1_pos(x_pos), .x1_neg(x_neg),
      .x2_pos(x2_pos), .x2_neg(x2_neg),
      .x3_pos(x3_pos), .x3_neg(x3_neg),
      .hi_pos(y_pos[2*i+1]), .hi_neg(y_neg[2*i+1]),
      .lo_pos(y_pos[2*i]),   .lo_neg(y_neg[2*i]),
      .r_pos(rp_pos[i]), .r_neg(rp_neg[i])
    );
    sd_scale #(.N(N), .SHIFT(2*i), .MODE(MODE)) u_pos4 (
      .i_pos(rp_pos[i]), .i_neg(rp_neg[i]),
      .o_pos(pp_pos[i]), .o_neg(pp_neg[i])
    );
    assign pp_all_pos[i*N +: N] = pp_pos[i];
    assign pp_all_neg[i*N +: N] = pp_neg[i];
  end

  // Leaves of the heap-ordered tree; unused leaves carry zero.
  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < K) begin : g_use
      assign nd_pos[LEAVES-1+j] = pp_pos[j];
      assign nd_neg[LEAVES-1+j] = pp_neg[j];
    end else begin : g_pad
      assign nd_pos[LEAVES-1+j] = '0;
      assign nd_neg[LEAVES-1+j] = '0;
    end
  end

  for (genvar k = 0; k < LEAVES - 1; k++) begin : g_node
    sd_modadd #(.N(N), .MODE(MODE)) u_add (
      .a_pos(nd_pos[2*k+1]), .a_neg(nd_neg[2*k+1]),
      .b_pos(nd_pos[2*k+2]), .b_neg(nd_neg[2*k+2]),
      .s_pos(nd_pos[k]),     .s_neg(nd_neg[k])
    );
  end

  assign p_pos = nd_pos[0];
  assign p_neg = nd_neg[0];

endmodule

// File: rtl/sd_modmul_chk.sv
// Assertion checker attached to every sd_modmul instance.
module sd_modmul_chk
  import sdm_pkg::*;
#(
  parameter int   N    = 6,
  parameter mod_e MODE = MOD_PLUS1
) (
  input logic [N-1:0]       x_pos,
  input logic [N-1:0]       x_neg,
  input logic [N-1:0]       y_pos,
  input logic [N-1:0]       y_neg,
  input logic [N-1:0]       p_pos,
  input logic [N-1:0]       p_neg,
  input logic [N-1:0]       x3_pos,
  input logic [N-1:0]       x3_neg,
  input logic [(N/2)*N-1:0] pp_all_pos,
  input logic [(N/2)*N-1:0] pp_all_neg
);

  localparam longint MODV = (MODE == MOD_MINUS1) ? (longint'(1) << N) - 1 :
                            (MODE == MOD_POW2)   ? (longint'(1) << N) :
                                                   (longint'(1) << N) + 1;

  logic   inputs_ok;
  longint xv, yv, pv, tv;

  assign inputs_ok = ((x_pos & x_neg) == '0) && ((y_pos & y_neg) == '0);
  assign xv = sd_val(32'(x_pos), 32'(x_neg));
  assign yv = sd_val(32'(y_pos), 32'(y_neg));
  assign pv = sd_val(32'(p_pos), 32'(p_neg));
  assign tv = sd_val(32'(x3_pos), 32'(x3_neg));

  always_comb begin
    if (inputs_ok) begin
      // R1
      no_bad_digit_chk: assert ((p_pos & p_neg) == '0)
        else $error("output digit with both flags set");
      // R1
      pp_digit_chk: assert ((pp_all_pos & pp_all_neg) == '0)
        else $error("partial product digit with both flags set");
      // R2 R3 R4
      triple_residue_chk: assert (((tv - 3 * xv) % MODV) == 0)
        else $error("triple of x not congruent to 3x");
      // R2 R3 R4
      product_residue_chk: assert (((pv - xv * yv) % MODV) == 0)
        else $error("product not congruent to x*y");
      // R5
      zero_operand_chk: assert (!((x_pos | x_neg) == '0 || (y_pos | y_neg) == '0)
                                || (p_pos | p_neg) == '0)
        else $error("zero operand gave nonzero digits");
    end
  end

endmodule

bind sd_modmul sd_modmul_chk #(.N(N), .MODE(MODE)) u_chk (
  .x_pos(x_pos), .x_neg(x_neg), .y_pos(y_pos), .y_neg(y_neg),
  .p_pos(p_pos), .p_neg(p_neg), .x3_pos(x3_pos), .x3_neg(x3_neg),
  .pp_all_pos(pp_all_pos), .pp_all_neg(pp_all_neg)
);

// File: tb/sd_modmul_test.sv
module sd_modmul_test;
  import sdm_pkg::*;

  localparam int N          = 6;
  localparam int CLK_PERIOD = 10;
  localparam int NPAT       = 729;  // 3^N digit patterns

  logic clk = 1'b0;
  logic rst = 1'b1;
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  logic [N-1:0] x_pos = '0, x_neg = '0, y_pos = '0, y_neg = '0;
  logic [N-1:0] pp1, pn1, pp0, pn0, ppw, pnw;

  always #(CLK_PERIOD/2) clk = ~clk;

  sd_modmul #(.N(N), .MODE(MOD_PLUS1)) uut (
    .x_pos(x_pos), .x_neg(x_neg), .y_pos(y_pos), .y_neg(y_neg),
    .p_pos(pp1), .p_neg(pn1)
  );
  sd_modmul #(.N(N), .MODE(MOD_MINUS1)) uut_minus (
    .x_pos(x_pos), .x_neg(x_neg), .y_pos(y_pos), .y_neg(y_neg),
    .p_pos(pp0), .p_neg(pn0)
  );
  sd_modmul #(.N(N), .MODE(MOD_POW2)) uut_pow2 (
    .x_pos(x_pos), .x_neg(x_neg), .y_pos(y_pos), .y_neg(y_neg),
    .p_pos(ppw), .p_neg(pnw)
  );

  // Horner evaluation of an SD vector, most significant digit first.
  function automatic longint dv(input logic [N-1:0] p, input logic [N-1:0] n);
    longint v = 0;
    for (int i = N - 1; i >= 0; i--) v = 2 * v + (p[i] ? 1 : 0) - (n[i] ? 1 : 0);
    return v;
  endfunction

  function automatic longint modr(input longint v, input longint m);
    return ((v % m) + m) % m;
  endfunction

  // Base-3 index to digits: 0 -> 0, 1 -> +1, 2 -> -1.
  task automatic pat(input int idx, output logic [N-1:0] p, output logic [N-1:0] n);
    int v = idx;
    p = '0; n = '0;
    for (int d = 0; d < N; d++) begin
      if (v % 3 == 1) p[d] = 1'b1;
      else if (v % 3 == 2) n[d] = 1'b1;
      v = v / 3;
    end
  endtask

  task automatic chk_res(input string req, input logic [N-1:0] p, input logic [N-1:0] n,
                         input longint m);
    longint exp_r, got_r;
    exp_r = modr(dv(x_pos, x_neg) * dv(y_pos, y_neg), m);
    got_r = modr(dv(p, n), m);
    checks++;
    if (got_r != exp_r) begin
      errors++;
      $display("FAIL %s mod %0d: x=%0d y=%0d actual residue %0d expected %0d",
               req, m, dv(x_pos, x_neg), dv(y_pos, y_neg), got_r, exp_r);
    end
    checks++;
    if ((p & n) != '0) begin
      errors++;
      $display("FAIL R1: bad digit actual %b/%b expected no shared bit", p, n);
    end
  endtask

  // R7: operands driven after a rising edge, results read at the next falling edge.
  task automatic apply(input logic [N-1:0] xp, input logic [N-1:0] xn,
                       input logic [N-1:0] yp, input logic [N-1:0] yn);
    @(posedge clk);
    x_pos = xp; x_neg = xn; y_pos = yp; y_neg = yn;
    @(negedge clk);
    chk_res("R2", pp0, pn0, (longint'(1) << N) - 1);
    chk_res("R3", ppw, pnw, (longint'(1) << N));
    chk_res("R4", pp1, pn1, (longint'(1) << N) + 1);
    if ((xp | xn) == '0 || (yp | yn) == '0) begin
      checks++;
      if ((pp0 | pn0 | ppw | pnw | pp1 | pn1) != '0) begin
        errors++;
        $display("FAIL R5: actual %b %b %b expected all zero digits",
                 pp0 | pn0, ppw | pnw, pp1 | pn1);
      end
    end
  endtask

  initial begin
    logic [N-1:0] ap, an, bp, bn;
    logic [N-1:0] s0p, s0n, s1p, s1n, s2p, s2n;
    logic [15:0]  lfsr;
    repeat (3) @(posedge clk);
    rst = 1'b0;

    // Quiet state with all-zero operands (R5, R7).
    @(negedge clk);
    checks++;
    if ((pp0 | pn0 | ppw | pnw | pp1 | pn1) != '0) begin
      errors++;
      $display("FAIL R5: initial outputs nonzero, expected zero");
    end

    // Every multiplier pattern against a varying multiplicand (R2 R3 R4).
    for (int i = 0; i < NPAT; i++) begin
      pat((i * 37 + 11) % NPAT, ap, an);
      pat(i, bp, bn);
      apply(ap, an, bp, bn);
    end
    // Every multiplicand pattern against a varying multiplier.
    for (int i = 0; i < NPAT; i++) begin
      pat(i, ap, an);
      pat((i * 113 + 5) % NPAT, bp, bn);
      apply(ap, an, bp, bn);
    end
    // Zero operands and all-extreme operands (R5, boundaries).
    for (int i = 0; i < NPAT; i += 13) begin
      pat(i, ap, an);
      apply(ap, an, '0, '0);
      apply('0, '0, ap, an);
    end
    apply('1, '0, '1, '0);
    apply('0, '1, '1, '0);
    apply('0, '1, '0, '1);
    // Pseudo-random pairs.
    lfsr = 16'hACE1;
    for (int i = 0; i < 1500; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pat(int'(lfsr) % NPAT, ap, an);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      pat(int'(lfsr) % NPAT, bp, bn);
      apply(ap, an, bp, bn);
    end

    // R6: low pair (+1,-1) versus (0,+1) must give identical digits.
    for (int u = 0; u < 81; u++) begin
      pat((u * 53 + 7) % NPAT, ap, an);
      pat(u * 9, bp, bn);            // low two digits zero
      apply(ap, an, bp | 6'b000001, bn);
      s0p = pp0; s0n = pn0; s1p = ppw; s1n = pnw; s2p = pp1; s2n = pn1;
      apply(ap, an, bp | 6'b000010, bn | 6'b000001);
      checks++;
      if ({s0p, s0n, s1p, s1n, s2p, s2n} != {pp0, pn0, ppw, pnw, pp1, pn1}) begin
        errors++;
        $display("FAIL R6: actual %b%b %b%b %b%b expected %b%b %b%b %b%b",
                 pp0, pn0, ppw, pnw, pp1, pn1, s0p, s0n, s1p, s1n, s2p, s2n);
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule